// File: doc/BRIEF.md
# Timer compare match output unit

This unit watches one of two external 16-bit free-running counts and compares it with a programmed 16-bit compare value. When the selected count first becomes equal to the compare value, the unit updates its compare output latch as the mode field dictates: it can set the latch, clear it, toggle it, or leave it alone. In the same clock edge it sets a sticky interrupt flag. Software clears that flag with a write-one-to-clear strobe.

One mode raises only the flag and leaves the latch alone. This gives a timed software interrupt. Another mode produces a one-clock internal trigger. The trigger resets whichever timer is selected, so the compare value works as a programmable period. When the converter enable input is high, the trigger also asks the ADC for a conversion. The timers, the ADC and the interrupt controller are outside the block. The pin is driven only while the external tristate control is low.

Top module: `cmp_match_unit`

## Requirements
- R1: The comparison uses only the count chosen by control bit 4 (0 = `tmr_a_i`, 1 = `tmr_b_i`). An equal value on the other count has no effect on the latch, the flag or the strobes.
- R2: The latch changes on the clock edge at which the selected count first equals the compare value. Mode 4'b1000 sets it, mode 4'b1001 clears it and mode 4'b0010 inverts it. Control bits 3:0 hold the mode.
- R3: In modes 4'b1000, 4'b1001, 4'b0010, 4'b1010 and 4'b1011, a match sets `flag_o` on that same edge. The flag stays set until a cycle with `flag_clr_i` high clears it, and a set in the same cycle wins over the clear.
- R4: In mode 4'b1010 a match sets only the flag. The latch keeps its value.
- R5: In mode 4'b1011 a match gives a one-clock pulse on `trig_o` together with a one-clock pulse on the reset strobe of the selected timer only. The latch keeps its value.
- R6: `adc_start_o` pulses with `trig_o` only when `adc_en_i` was high in the cycle of the match.
- R7: A write of zero to control bits 4:0 (address 1) drives the latch low on that edge. Address 0 writes the compare value.
- R8: In any mode outside the five listed in R3, a match changes neither the latch nor the flag.
- R9: A selected count that stays equal to the compare value acts only once. Another action needs the count to leave the value and come back.
- R10: After reset the latch, flag and strobes are low. `pin_oe_o` is the inverse of `pin_tris_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 1 | 0 = compare value, 1 = control |
| cfg_wdata_i | input | 16 | Write data; control uses bits 4:0 |
| flag_clr_i | input | 1 | Write-one-to-clear for the flag |
| tmr_a_i | input | 16 | Count of timer A |
| tmr_b_i | input | 16 | Count of timer B |
| adc_en_i | input | 1 | Converter enabled |
| pin_tris_i | input | 1 | Tristate control, 1 = pin not driven |
| pin_o | output | 1 | Compare output latch |
| pin_oe_o | output | 1 | Pin output enable |
| flag_o | output | 1 | Sticky interrupt flag |
| trig_o | output | 1 | Special event trigger pulse |
| tmr_a_rst_o | output | 1 | Reset strobe for timer A |
| tmr_b_rst_o | output | 1 | Reset strobe for timer B |
| adc_start_o | output | 1 | Conversion request pulse |

## Verification
The hardest situation to reach from the ports is a match that must not repeat: a count held at the compare value for several cycles. In toggle mode a repeated action would show as a flickering latch. The bench holds the selected count steady for four cycles and checks that the latch inverted exactly once. A second case is a match that starts from a latch that is already high, which is what shows that the flag-only and unknown modes leave the latch alone. To get there, each vector first forces the latch high with a set-mode match, clears the flag, and only then writes the mode under test.

// File: rtl/cmp_match_pkg.sv
package cmp_match_pkg;
  localparam logic [3:0] MODE_OFF     = 4'b0000;
  localparam logic [3:0] MODE_TOGGLE  = 4'b0010;
  localparam logic [3:0] MODE_SET     = 4'b1000;
  localparam logic [3:0] MODE_CLR     = 4'b1001;
  localparam logic [3:0] MODE_SWINT   = 4'b1010;
  localparam logic [3:0] MODE_SPECIAL = 4'b1011;

  typedef struct packed {
    logic       sel;
    logic [3:0] mode;
  } ctrl_t;

  function automatic logic is_cmp_mode(logic [3:0] m);
    return (m == MODE_TOGGLE) || (m == MODE_SET) || (m == MODE_CLR) ||
           (m == MODE_SWINT) || (m == MODE_SPECIAL);
  endfunction
endpackage

// File: rtl/cmp_regs.sv
module cmp_regs
  import cmp_match_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic         addr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] cmp_o,
  output ctrl_t        ctrl_o,
  output logic         zero_wr_o
);
  localparam int unsigned CW = $bits(ctrl_t);

  logic [W-1:0] cmp_q;
  ctrl_t        ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmp_q  <= '0;
      ctrl_q <= '0;
    end else if (we_i) begin
      if (addr_i) ctrl_q <= ctrl_t'(wdata_i[CW-1:0]);
      else        cmp_q  <= wdata_i;
    end
  end

  assign zero_wr_o = we_i && addr_i && (wdata_i[CW-1:0] == '0);
  assign cmp_o     = cmp_q;
  assign ctrl_o    = ctrl_q;
endmodule

// File: rtl/cmp_detect.sv
module cmp_detect #(
  parameter int unsigned W     = 16,
  parameter int unsigned N_TMR = 2,
  localparam int unsigned SW   = (N_TMR > 1) ? $clog2(N_TMR) : 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [SW-1:0]         sel_i,
  input  logic [N_TMR-1:0][W-1:0] tmr_i,
  input  logic [W-1:0]          cmp_i,
  output logic                  match_o
);
  logic eq, eq_q;

  assign eq = (tmr_i[sel_i] == cmp_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) eq_q <= 1'b0;
    else         eq_q <= eq;
  end

  // act on the rising edge of equality only
  assign match_o = eq && !eq_q;
endmodule

// File: rtl/cmp_action.sv
module cmp_action
  import cmp_match_pkg::*;
#(
  parameter int unsigned N_TMR = 2,
  localparam int unsigned SW   = (N_TMR > 1) ? $clog2(N_TMR) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             match_i,
  input  logic [3:0]       mode_i,
  input  logic [SW-1:0]    sel_i,
  input  logic             zero_wr_i,
  input  logic             flag_clr_i,
  input  logic             adc_en_i,
  output logic             latch_o,
  output logic             flag_o,
  output logic             trig_o,
  output logic [N_TMR-1:0] tmr_rst_o,
  output logic             adc_o
);
  logic          latch_q, flag_q, trig_q, adc_q;
  logic [SW-1:0] sel_q;
  logic          special;

  assign special = match_i && (mode_i == MODE_SPECIAL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      latch_q <= 1'b0;
      flag_q  <= 1'b0;
      trig_q  <= 1'b0;
      adc_q   <= 1'b0;
      sel_q   <= '0;
    end else begin
      trig_q <= special;
      adc_q  <= special && adc_en_i;
      sel_q  <= sel_i;
      if (zero_wr_i) latch_q <= 1'b0;
      else if (match_i) begin
        unique case (mode_i)
          MODE_SET:    latch_q <= 1'b1;
          MODE_CLR:    latch_q <= 1'b0;
          MODE_TOGGLE: latch_q <= !latch_q;
          default:     latch_q <= latch_q;
        endcase
      end
      if (match_i && is_cmp_mode(mode_i)) flag_q <= 1'b1;
      else if (flag_clr_i)                flag_q <= 1'b0;
    end
  end

  for (genvar k = 0; k < N_TMR; k++) begin : g_rst
    assign tmr_rst_o[k] = trig_q && (sel_q == SW'(k));
  end

  assign latch_o = latch_q;
  assign flag_o  = flag_q;
  assign trig_o  = trig_q;
  assign adc_o   = adc_q;
endmodule

// File: rtl/cmp_match_unit.sv
module cmp_match_unit
  import cmp_match_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         cfg_we_i,
  input  logic         cfg_addr_i,
  input  logic [W-1:0] cfg_wdata_i,
  input  logic         flag_clr_i,
  input  logic [W-1:0] tmr_a_i,
  input  logic [W-1:0] tmr_b_i,
  input  logic         adc_en_i,
  input  logic         pin_tris_i,
  output logic         pin_o,
  output logic         pin_oe_o,
  output logic         flag_o,
  output logic         trig_o,
  output logic         tmr_a_rst_o,
  output logic         tmr_b_rst_o,
  output logic         adc_start_o
);
  localparam int unsigned N_TMR = 2;

  logic [W-1:0]            cmp_val;
  ctrl_t                   ctrl;
  logic                    zero_wr, match;
  logic [N_TMR-1:0][W-1:0] tmr_vec;
  logic [N_TMR-1:0]        rst_vec;

  assign tmr_vec[0] = tmr_a_i;
  assign tmr_vec[1] = tmr_b_i;

  cmp_regs #(.W(W)) u_regs (
    .clk_i, .rst_ni,
    .we_i      (cfg_we_i),
    .addr_i    (cfg_addr_i),
    .wdata_i   (cfg_wdata_i),
    .cmp_o     (cmp_val),
    .ctrl_o    (ctrl),
    .zero_wr_o (zero_wr)
  );

  cmp_detect #(.W(W), .N_TMR(N_TMR)) u_detect (
    .clk_i, .rst_ni,
    .sel_i   (ctrl.sel),
    .tmr_i   (tmr_vec),
    .cmp_i   (cmp_val),
    .match_o (match)
  );

  cmp_action #(.N_TMR(N_TMR)) u_action (
    .clk_i, .rst_ni,
    .match_i    (match),
    .mode_i     (ctrl.mode),
    .sel_i      (ctrl.sel),
    .zero_wr_i  (zero_wr),
    .flag_clr_i (flag_clr_i),
    .adc_en_i   (adc_en_i),
    .latch_o    (pin_o),
    .flag_o     (flag_o),
    .trig_o     (trig_o),
    .tmr_rst_o  (rst_vec),
    .adc_o      (adc_start_o)
  );

  assign tmr_a_rst_o = rst_vec[0];
  assign tmr_b_rst_o = rst_vec[1];
  assign pin_oe_o    = !pin_tris_i;
endmodule

// File: rtl/cmp_match_unit_chk.sv
module cmp_match_unit_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic cfg_we_i,
  input logic flag_clr_i,
  input logic adc_en_i,
  input logic pin_o,
  input logic flag_o,
  input logic trig_o,
  input logic tmr_a_rst_o,
  input logic tmr_b_rst_o,
  input logic adc_start_o
);
  AST_TRIG_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_o |=> !trig_o); // R5
  AST_TRIG_HAS_RST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_o |-> (tmr_a_rst_o || tmr_b_rst_o)); // R5
  AST_RST_ONE_TIMER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({tmr_a_rst_o, tmr_b_rst_o})); // R5
  AST_ADC_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adc_start_o |-> (trig_o && $past(adc_en_i))); // R6
  AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(flag_o) && !$past(flag_clr_i)) |-> flag_o); // R3
  AST_PIN_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(pin_o) |-> (flag_o || $past(cfg_we_i))); // R8
endmodule

bind cmp_match_unit cmp_match_unit_chk u_chk (
  .clk_i, .rst_ni, .cfg_we_i, .flag_clr_i, .adc_en_i, .pin_o, .flag_o,
  .trig_o, .tmr_a_rst_o, .tmr_b_rst_o, .adc_start_o
);

// File: tb/cmp_match_unit_tb_top.sv
module cmp_match_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0, addr = 1'b0, clr = 1'b0, adc_en = 1'b0, tris = 1'b1;
  logic [15:0] wdata = '0, ta = 16'h8000, tb = 16'h8000;
  logic        pin, oe, flag, trig, ra, rb, adc;
  int          n_chk = 0, n_fail = 0;

  always #5 clk = !clk;

  cmp_match_unit dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(we), .cfg_addr_i(addr),
    .cfg_wdata_i(wdata), .flag_clr_i(clr), .tmr_a_i(ta), .tmr_b_i(tb),
    .adc_en_i(adc_en), .pin_tris_i(tris), .pin_o(pin), .pin_oe_o(oe),
    .flag_o(flag), .trig_o(trig), .tmr_a_rst_o(ra), .tmr_b_rst_o(rb),
    .adc_start_o(adc)
  );

  // {init_hi, sel, adc_en, mode[3:0], exp pin, flag, trig, adc}
  localparam logic [10:0] VEC [8] = '{
    {3'b000, 4'b1000, 4'b1100},
    {3'b100, 4'b1001, 4'b0100},
    {3'b010, 4'b0010, 4'b1100},
    {3'b100, 4'b0010, 4'b0100},
    {3'b110, 4'b1010, 4'b1100},
    {3'b001, 4'b1011, 4'b0111},
    {3'b100, 4'b0101, 4'b1000},
    {3'b010, 4'b1011, 4'b0110}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [15:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic clear_flag();
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
  endtask

  task automatic away(input logic [15:0] c);
    ta = c ^ 16'h8000; tb = c ^ 16'h8000;
  endtask

  // put selected count on the compare value, sample after the edge
  task automatic hit(input logic s, input logic [15:0] c);
    @(negedge clk);
    if (s) tb = c; else ta = c;
    @(posedge clk); #1;
  endtask

  initial begin
    repeat (2) @(negedge clk);
    #1;
    check("R10 reset", {4'b0, pin, flag, trig, adc}, 8'h0);
    rst_n = 1'b1;
    tris = 1'b0; #1;
    check("R10 oe", {7'b0, oe}, 8'h1);
    tris = 1'b1; #1;
    check("R10 oe off", {7'b0, oe}, 8'h0);

    for (int i = 0; i < 8; i++) begin
      logic [15:0] c;
      c = 16'h1234 + 16'(i) * 16'h0111;
      away(c);
      wr(1'b1, 16'h0);
      wr(1'b0, c);
      if (VEC[i][10]) begin
        wr(1'b1, 16'h0008);
        hit(1'b0, c);
        @(negedge clk); away(c);
      end
      clear_flag();
      adc_en = VEC[i][8];
      wr(1'b1, {11'b0, VEC[i][9], VEC[i][7:4]});
      hit(VEC[i][9], c);
      check($sformatf("R2/R3/R4/R5/R6/R8 vec%0d", i),
            {2'b0, ra, rb, pin, flag, trig, adc},
            {2'b0, VEC[i][1] & !VEC[i][9], VEC[i][1] & VEC[i][9], VEC[i][3:0]});
      @(negedge clk); away(c);
      @(posedge clk); #1;
      check($sformatf("R5 pulse end vec%0d", i), {6'b0, trig, flag}, {7'b0, VEC[i][2]});
    end
    adc_en = 1'b0;

    // R9: held equality in toggle mode acts once
    away(16'h0400);
    wr(1'b1, 16'h0); wr(1'b0, 16'h0400); clear_flag();
    wr(1'b1, 16'h0002);
    hit(1'b0, 16'h0400);
    repeat (3) @(posedge clk);
    #1;
    check("R9 held match", {7'b0, pin}, 8'h1);

    // R3: flag sticky, then cleared
    @(negedge clk); away(16'h0400);
    repeat (3) @(posedge clk);
    #1;
    check("R3 sticky", {7'b0, flag}, 8'h1);
    clear_flag(); #1;
    check("R3 cleared", {7'b0, flag}, 8'h0);

    // R7: zero control write clears latch
    wr(1'b1, 16'h0); #1;
    check("R7 zero write", {7'b0, pin}, 8'h0);

    // R1: equality on the unselected count is ignored
    wr(1'b1, 16'h0008);
    hit(1'b1, 16'h0400);
    @(posedge clk); #1;
    check("R1 unselected", {6'b0, pin, flag}, 8'h0);
    hit(1'b0, 16'h0400);
    check("R1 selected", {6'b0, pin, flag}, 8'h3);

    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule